// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Logic

This block gives two ports, called left and right, a pair of mailbox words with an interrupt flag in each direction. Both mailbox words sit at the top of a 13-bit word address space. The word at 0x1FFF carries messages to the right port. The word at 0x1FFE carries messages to the left port. When one port writes the slot that the other side receives on, the receiver's active-low interrupt output goes low. When the receiver reads its own slot, that read acknowledges the message and releases the interrupt. No separate interrupt register exists. Setting and clearing are side effects of ordinary accesses to fixed addresses.

Each port presents chip select, a read/write strobe, output enable, an address and write data, all sampled on one shared clock. Read data is registered and appears one cycle after a qualified read. A port may read either mailbox word. Only a read of its own slot clears a flag. The message contents carry no meaning for the block; they are stored and returned like any memory word.

Top module: `mbox_irq_pair`

## Requirements
- R1: After a synchronous reset, both interrupt outputs are 1 (inactive) and both read data outputs are 0.
- R2: A left write (cs_n=0, rw=0) to address 0x1FFF drives r_irq_n to 0 from the next clock edge.
- R3: A right read (cs_n=0, rw=1, oe_n=0) of address 0x1FFF drives r_irq_n back to 1 from the next clock edge.
- R4: A right write to address 0x1FFE drives l_irq_n to 0 from the next clock edge.
- R5: A left read of address 0x1FFE drives l_irq_n back to 1 from the next clock edge.
- R6: Each mailbox word keeps the last data written to it by either port. A qualified read of 0x1FFE or 0x1FFF returns that word on rdata after the next edge. A read in the same cycle as a write to that word returns the value held before the write.
- R7: An access counts as a write only with cs_n=0 and rw=0. It counts as a read only with cs_n=0, rw=1 and oe_n=0. Any other combination leaves both flags, both words and that port's rdata unchanged.
- R8: If a set and a clear of the same flag fall in one cycle, the flag ends up set (interrupt output 0).
- R9: A port writing its own receive slot, or reading the other port's receive slot, changes neither interrupt output.
- R10: If both ports write the same mailbox word in one cycle, the left port's data is stored.
- R11: Accesses to any address other than 0x1FFE and 0x1FFF leave both flags and both words unchanged, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left chip select, active low |
| l_rw | input | 1 | Left strobe: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 13 | Left word address |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low, always driven |
| r_cs_n | input | 1 | Right chip select, active low |
| r_rw | input | 1 | Right strobe: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 13 | Right word address |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low, always driven |

## Verification
Two events can fall in one cycle. The first is a sender posting a message while the receiver acknowledges the previous one. The second is both ports writing the same word, or one port reading a word that the other is writing. Directed cycles set up each overlap on purpose. Random cycles with addresses biased toward the two mailbox slots hit them again many times. A bench model decides the winner by the rules above: set beats clear, left data beats right data, and a read returns the old word. Its prediction is compared with both interrupt outputs and both read buses after every edge.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    localparam int NPORT     = 2;
    localparam int PORT_LEFT = 0;
    localparam int PORT_RGHT = 1;

    // Decoded view of one port's access in the current cycle.
    typedef struct packed {
        logic wr;    // qualified write
        logic rd;    // qualified read
        logic hit;   // address falls on one of the two mailbox words
        logic slot;  // 0: word received by left, 1: word received by right
    } mbox_acc_t;

    function automatic logic is_write(input logic cs_n, input logic rw);
        return !cs_n && !rw;
    endfunction

    function automatic logic is_read(input logic cs_n, input logic rw, input logic oe_n);
        return !cs_n && rw && !oe_n;
    endfunction

    // A port's own receive slot index equals its port index.
    function automatic logic own_slot(input int port);
        return (port == PORT_RGHT);
    endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_irq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              cs_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output mbox_acc_t         acc
);

    localparam int TOP_W = ADDR_W - 1;

    logic top_ones;

    // Both mailbox words share every address bit except the lowest.
    assign top_ones = &addr[ADDR_W-1:ADDR_W-TOP_W];

    always_comb begin
        acc.wr   = is_write(cs_n, rw);
        acc.rd   = is_read(cs_n, rw, oe_n);
        acc.hit  = top_ones;
        acc.slot = addr[0];
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);

    logic pending;

    // Set takes priority so a message posted during an acknowledge survives.
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set_i) begin
            pending <= 1'b1;
        end else if (clr_i) begin
            pending <= 1'b0;
        end
    end

    assign irq_n = !pending;

endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_irq_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  mbox_acc_t         acc   [NPORT],
    input  logic [DATA_W-1:0] wdata [NPORT],
    output logic [DATA_W-1:0] rdata [NPORT]
);

    localparam int NSLOT = 2;

    logic [DATA_W-1:0] word_q [NSLOT];

    // Word storage: ports are scanned from highest index down, so the
    // lowest-numbered (left) port's assignment is the one that lands.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[s] <= '0;
            end else begin
                for (int p = NPORT - 1; p >= 0; p--) begin
                    if (acc[p].wr && acc[p].hit && (int'(acc[p].slot) == s)) begin
                        word_q[s] <= wdata[p];
                    end
                end
            end
        end
    end

    // Registered read per port; holds when the port does not read.
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[p] <= '0;
            end else if (acc[p].rd) begin
                rdata[p] <= acc[p].hit ? word_q[acc[p].slot] : '0;
            end
        end
    end

endmodule

// File: rtl/mbox_irq_pair.sv
module mbox_irq_pair
    import mbox_irq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    logic              cs_n_a  [NPORT];
    logic              rw_a    [NPORT];
    logic              oe_n_a  [NPORT];
    logic [ADDR_W-1:0] addr_a  [NPORT];
    logic [DATA_W-1:0] wdata_a [NPORT];
    logic [DATA_W-1:0] rdata_a [NPORT];
    logic              irq_n_a [NPORT];
    mbox_acc_t         acc     [NPORT];

    assign cs_n_a[PORT_LEFT]  = l_cs_n;
    assign rw_a[PORT_LEFT]    = l_rw;
    assign oe_n_a[PORT_LEFT]  = l_oe_n;
    assign addr_a[PORT_LEFT]  = l_addr;
    assign wdata_a[PORT_LEFT] = l_wdata;
    assign cs_n_a[PORT_RGHT]  = r_cs_n;
    assign rw_a[PORT_RGHT]    = r_rw;
    assign oe_n_a[PORT_RGHT]  = r_oe_n;
    assign addr_a[PORT_RGHT]  = r_addr;
    assign wdata_a[PORT_RGHT] = r_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int OTHER = NPORT - 1 - p;

        logic set_w;
        logic clr_w;

        mbox_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .cs_n (cs_n_a[p]),
            .rw   (rw_a[p]),
            .oe_n (oe_n_a[p]),
            .addr (addr_a[p]),
            .acc  (acc[p])
        );

        // Flag of port p: raised by the other port writing p's slot,
        // dropped by p reading its own slot.
        assign set_w = acc[OTHER].wr && acc[OTHER].hit && (acc[OTHER].slot == own_slot(p));
        assign clr_w = acc[p].rd && acc[p].hit && (acc[p].slot == own_slot(p));

        mbox_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_w),
            .clr_i (clr_w),
            .irq_n (irq_n_a[p])
        );
    end

    mbox_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (wdata_a),
        .rdata (rdata_a)
    );

    assign l_rdata = rdata_a[PORT_LEFT];
    assign r_rdata = rdata_a[PORT_RGHT];
    assign l_irq_n = irq_n_a[PORT_LEFT];
    assign r_irq_n = irq_n_a[PORT_RGHT];

endmodule

// File: rtl/mbox_irq_pair_chk.sv
module mbox_irq_pair_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] TO_RIGHT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] TO_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic l_wr, l_rd, r_wr, r_rd;
    logic set_r, clr_r, set_l, clr_l;
    logic l_off, r_off;

    assign l_wr  = !l_cs_n && !l_rw;
    assign l_rd  = !l_cs_n && l_rw && !l_oe_n;
    assign r_wr  = !r_cs_n && !r_rw;
    assign r_rd  = !r_cs_n && r_rw && !r_oe_n;
    assign set_r = l_wr && (l_addr == TO_RIGHT);
    assign clr_r = r_rd && (r_addr == TO_RIGHT);
    assign set_l = r_wr && (r_addr == TO_LEFT);
    assign clr_l = l_rd && (l_addr == TO_LEFT);
    assign l_off = (l_addr != TO_RIGHT) && (l_addr != TO_LEFT);
    assign r_off = (r_addr != TO_RIGHT) && (r_addr != TO_LEFT);

    // R2 and R8: a left post to the right slot always lands
    a_r2_right_set: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_irq_n);

    // R3
    a_r3_right_clear: assert property (@(posedge clk) disable iff (rst)
        clr_r && !set_r |=> r_irq_n);

    // R4 and R8
    a_r4_left_set: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_irq_n);

    // R5
    a_r5_left_clear: assert property (@(posedge clk) disable iff (rst)
        clr_l && !set_l |=> l_irq_n);

    // R9 and R7: without its own set or clear a flag holds
    a_r9_right_hold: assert property (@(posedge clk) disable iff (rst)
        !set_r && !clr_r |=> $stable(r_irq_n));

    a_r9_left_hold: assert property (@(posedge clk) disable iff (rst)
        !set_l && !clr_l |=> $stable(l_irq_n));

    // R11
    a_r11_left_offread: assert property (@(posedge clk) disable iff (rst)
        l_rd && l_off |=> l_rdata == '0);

    a_r11_right_offread: assert property (@(posedge clk) disable iff (rst)
        r_rd && r_off |=> r_rdata == '0);

    // R7: a port that does not read keeps its read data
    a_r7_left_hold: assert property (@(posedge clk) disable iff (rst)
        !l_rd |=> $stable(l_rdata));

    a_r7_right_hold: assert property (@(posedge clk) disable iff (rst)
        !r_rd |=> $stable(r_rdata));

endmodule

bind mbox_irq_pair mbox_irq_pair_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mbox_irq_pair.sv
module tb_mbox_irq_pair;

    localparam int AW = 13;
    localparam int DW = 9;
    localparam logic [AW-1:0] A_TO_R = 13'h1FFF;
    localparam logic [AW-1:0] A_TO_L = 13'h1FFE;

    logic          clk = 1'b0;
    logic          rst;
    logic          l_cs_n, l_rw, l_oe_n, r_cs_n, r_rw, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;

    // bench model
    logic          m_lflag, m_rflag;
    logic [DW-1:0] m_word [2];
    logic [DW-1:0] m_lrd, m_rrd;
    string         tag_l, tag_r;

    always #10 clk = ~clk;

    mbox_irq_pair #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .l_cs_n(l_cs_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    function automatic logic f_wr(input logic cs_n, input logic rw);
        return !cs_n && !rw;
    endfunction

    function automatic logic f_rd(input logic cs_n, input logic rw, input logic oe_n);
        return !cs_n && rw && !oe_n;
    endfunction

    function automatic logic f_hit(input logic [AW-1:0] a);
        return (a == A_TO_R) || (a == A_TO_L);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic lc, input logic lr, input logic lo, input logic [AW-1:0] la,
                         input logic [DW-1:0] ld, input logic rc, input logic rr, input logic ro,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        l_cs_n = lc; l_rw = lr; l_oe_n = lo; l_addr = la; l_wdata = ld;
        r_cs_n = rc; r_rw = rr; r_oe_n = ro; r_addr = ra; r_wdata = rd;
    endtask

    // Apply the driven inputs across one edge, update the model, check outputs.
    task automatic step();
        logic lw, lrd, rw_, rrd, sr, cr, sl, cl;
        logic [DW-1:0] old0, old1;
        lw  = f_wr(l_cs_n, l_rw);
        lrd = f_rd(l_cs_n, l_rw, l_oe_n);
        rw_ = f_wr(r_cs_n, r_rw);
        rrd = f_rd(r_cs_n, r_rw, r_oe_n);
        sr = lw && (l_addr == A_TO_R);
        cr = rrd && (r_addr == A_TO_R);
        sl = rw_ && (r_addr == A_TO_L);
        cl = lrd && (l_addr == A_TO_L);
        tag_r = (sr && cr) ? "R8" : sr ? "R2" : cr ? "R3" : "R9";
        tag_l = (sl && cl) ? "R8" : sl ? "R4" : cl ? "R5" : "R9";
        old0 = m_word[0];
        old1 = m_word[1];
        if (lrd) m_lrd = f_hit(l_addr) ? (l_addr[0] ? old1 : old0) : '0;
        if (rrd) m_rrd = f_hit(r_addr) ? (r_addr[0] ? old1 : old0) : '0;
        if (rw_ && f_hit(r_addr)) m_word[r_addr[0]] = r_wdata;
        if (lw && f_hit(l_addr))  m_word[l_addr[0]] = l_wdata;   // R10 left wins
        if (sr) m_rflag = 1'b1; else if (cr) m_rflag = 1'b0;
        if (sl) m_lflag = 1'b1; else if (cl) m_lflag = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({tag_r, " r_irq_n"}, DW'(r_irq_n), DW'(!m_rflag));
        check({tag_l, " l_irq_n"}, DW'(l_irq_n), DW'(!m_lflag));
        check(lrd ? (f_hit(l_addr) ? "R6 l_rdata" : "R11 l_rdata") : "R7 l_rdata", l_rdata, m_lrd);
        check(rrd ? (f_hit(r_addr) ? "R6 r_rdata" : "R11 r_rdata") : "R7 r_rdata", r_rdata, m_rrd);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int u;
        u = int'($urandom_range(0, 9));
        if (u < 4) return A_TO_R;
        if (u < 8) return A_TO_L;
        return AW'($urandom_range(0, 13'h1FFD));
    endfunction

    localparam logic I = 1'b1;
    localparam logic O = 1'b0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        drive(I, I, I, '0, '0, I, I, I, '0, '0);
        rst = 1'b1;
        m_lflag = 0; m_rflag = 0; m_word[0] = '0; m_word[1] = '0; m_lrd = '0; m_rrd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 l_irq_n", DW'(l_irq_n), DW'(1));
        check("R1 r_irq_n", DW'(r_irq_n), DW'(1));
        check("R1 l_rdata", l_rdata, '0);
        check("R1 r_rdata", r_rdata, '0);

        // R2: left posts to right
        drive(O, O, I, A_TO_R, 9'h15A, I, I, I, '0, '0); step();
        // R9: right writes own slot, left reads right's slot -> no flag change
        drive(O, I, O, A_TO_R, '0, O, O, I, A_TO_R, 9'h033); step();
        // R7: right read with oe_n high -> no clear
        drive(I, I, I, '0, '0, O, I, I, A_TO_R, '0); step();
        // R3 + R6: right reads its slot
        drive(I, I, I, '0, '0, O, I, O, A_TO_R, '0); step();
        // R4: right posts to left
        drive(I, I, I, '0, '0, O, O, I, A_TO_L, 9'h0A5); step();
        // R8: left clears while right posts again in the same cycle
        drive(O, I, O, A_TO_L, '0, O, O, I, A_TO_L, 9'h1C3); step();
        // R5: left acknowledges
        drive(O, I, O, A_TO_L, '0, I, I, I, '0, '0); step();
        // R10: both write same word
        drive(O, O, I, A_TO_L, 9'h111, O, O, I, A_TO_L, 9'h0EE); step();
        // R6: read while the other port writes -> old value
        drive(O, I, O, A_TO_L, '0, O, O, I, A_TO_L, 9'h077); step();
        drive(O, I, O, A_TO_L, '0, I, I, I, '0, '0); step();
        // R11: off-mailbox writes and reads
        drive(O, O, I, 13'h0123, 9'h1FF, O, I, O, 13'h1FFD, '0); step();
        // R7: cs_n high write attempt
        drive(I, O, I, A_TO_R, 9'h0F0, I, O, I, A_TO_L, 9'h00F); step();

        for (int n = 0; n < 3000; n++) begin
            drive(logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 1)),
                  logic'($urandom_range(0, 4) == 0), pick_addr(), DW'($urandom),
                  logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 1)),
                  logic'($urandom_range(0, 4) == 0), pick_addr(), DW'($urandom));
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule